// File: doc/BRIEF.md
# Packet Counter and Status Interrupt Unit

This unit keeps the number of data packets that software has queued for a processing engine. It also turns the completion of each packet into sticky status flags and one interrupt line. Software adds to the count by writing an increment through a small register port. The engine pulses a completion strobe for each packet it finishes. The strobe carries that packet's chain flag, its interrupt-request flag and an 8-bit tag. Each completion takes one from the count.

The count is combined with the chain flag of the finishing packet. From this the unit detects two conditions. A chain error means the chain ended while packets were still queued. A wait-for-buffer condition means the chain continues but nothing more is queued. Both conditions, together with packet-done and count-reached-zero, are held in sticky bits. Software clears a bit by writing 1 to it. The interrupt is the OR of the enabled causes, gated by a global enable.

A three-state machine tracks the queue:
- EMPTY (code 0): count zero, no chained work pending.
- ACTIVE (code 1): count nonzero.
- STARVED (code 2): count zero after a chained completion.

Its transitions are:
- EMPTY→ACTIVE on a nonzero count.
- EMPTY→STARVED on a chained completion.
- ACTIVE→EMPTY when the count drops to zero on an unchained completion.
- ACTIVE→STARVED when the count drops to zero on a chained completion.
- STARVED→ACTIVE when software adds packets.

Top module: `pkt_status_unit`

## Requirements
- R1: After reset the control register, the count, the status flags, the tag and the irq output are all zero, and the queue state is EMPTY (code 0).
- R2: The register port has three registers. Address 0 is control, with irq enable in bit 0 and a test-force bit in bit 1. Address 1 is the counter. Address 2 is status. Address 3 reads as zero. A write to address 1 adds wdata[7:0] to the count. The count reads back in bits [23:16] of address 1, and writes to those bits have no effect.
- R3: Each completion strobe takes one from the count. A software increment and a completion in the same cycle both take effect.
- R4: The count saturates: it stays at 255 instead of wrapping upward, and a completion at count 0 leaves it at 0.
- R5: A completion whose interrupt-request flag is 1 sets the packet-done flag, status bit 2.
- R6: When the count changes from nonzero to zero, the count-zero flag, status bit 1, is set. A completion at a count that is already zero does not set it.
- R7: A completion with chain flag 1 that leaves the count at zero sets the wait-for-buffer flag, status bit 3.
- R8: A completion with chain flag 0 that leaves the count nonzero sets the chain-error flag, status bit 0.
- R9: Writing 1 to status bits [3:0] clears the matching flag, and writing 0 has no effect. If a set condition and a clear hit the same flag in the same cycle, the flag ends up set.
- R10: irq is high when the irq enable bit is 1 and at least one of these holds: chain-error is set, count-zero is set, packet-done is set, or wait-for-buffer is set while the test-force bit is 1.
- R11: Status bits [31:24] hold the tag of the most recent completion. Status bits [23:4] read zero.
- R12: Counter register bits [9:8] show the queue state: EMPTY=0, ACTIVE=1, STARVED=2. Its transitions are those listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pkt_done | input | 1 | One-cycle strobe: the engine finished a packet |
| pkt_chain | input | 1 | Chain flag of the finishing packet |
| pkt_irq_req | input | 1 | Interrupt-request flag of the finishing packet |
| pkt_tag | input | 8 | Tag of the finishing packet |
| irq | output | 1 | Interrupt output |

## Verification
The counting function is tested with these input patterns:
- Increments alone, completions alone, and an increment and a completion in the same cycle. Together these show whether the two sources add together or one overrides the other.
- Completions with chain flag 1 and with chain flag 0, each at a count that ends zero and at a count that stays nonzero. This separates the chain-error, wait-for-buffer and count-zero causes from each other.
- A completion at count zero, and repeated increments up to the top. These show whether the count saturates or wraps.
- Clears written at the same moment as a new set condition. These show which of the two wins.

// File: rtl/psu_pkg.sv
package psu_pkg;

    typedef enum logic [1:0] {
        CNT_EMPTY   = 2'd0,
        CNT_ACTIVE  = 2'd1,
        CNT_STARVED = 2'd2
    } cnt_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int FLG_CHAIN_ERR = 0;
    localparam int FLG_CNT_ZERO  = 1;
    localparam int FLG_PKT_DONE  = 2;
    localparam int FLG_WAIT_BUF  = 3;
    localparam int NUM_FLAGS     = 4;

endpackage

// File: rtl/psu_counter.sv
module psu_counter
    import psu_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_valid,
    input  logic [CNT_W-1:0] inc_val,
    input  logic             dec,
    input  logic             chain,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output cnt_state_e       state
);
    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

    logic [SUM_W-1:0] sum_add;
    logic [SUM_W-1:0] sum_sub;
    cnt_state_e       state_nxt;

    always_comb begin
        sum_add = {2'b00, count} + (inc_valid ? {2'b00, inc_val} : '0);
        if (dec && (sum_add != '0)) begin
            sum_sub = sum_add - 1'b1;
        end else begin
            sum_sub = sum_add;
        end
        if (sum_sub > CNT_MAX) begin
            count_nxt = {CNT_W{1'b1}};
        end else begin
            count_nxt = sum_sub[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    // Queue state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CNT_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CNT_EMPTY: begin
                if (count_nxt != '0) begin
                    state_nxt = CNT_ACTIVE;
                end else if (dec && chain) begin
                    state_nxt = CNT_STARVED;
                end
            end
            CNT_ACTIVE: begin
                if (count_nxt == '0) begin
                    state_nxt = (dec && chain) ? CNT_STARVED : CNT_EMPTY;
                end
            end
            CNT_STARVED: begin
                if (count_nxt != '0) begin
                    state_nxt = CNT_ACTIVE;
                end
            end
            default: state_nxt = CNT_EMPTY;
        endcase
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_valid && !dec) |=> (count == $past(count)));          // R3
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc_valid && (count != '0)) |=> (count == $past(count) - 1'b1)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_valid && !dec && (count == {CNT_W{1'b1}})) |=> (count == {CNT_W{1'b1}})); // R4
    AST_STARVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_STARVED) |-> (count == '0));                  // R12
    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CNT_ACTIVE) |-> (count != '0));                   // R12

endmodule

// File: rtl/psu_status.sv
module psu_status
    import psu_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TAG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 stat_wr,
    input  logic [1:0]           ctrl_wdata,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic                 done,
    input  logic                 chain,
    input  logic                 irq_req,
    input  logic [TAG_W-1:0]     tag,
    input  logic [CNT_W-1:0]     count,
    input  logic [CNT_W-1:0]     count_nxt,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [TAG_W-1:0]     tag_q,
    output logic                 irq_en,
    output logic                 test_force,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        set_vec[FLG_CHAIN_ERR] = done && !chain && (count_nxt != '0);
        set_vec[FLG_CNT_ZERO]  = (count != '0) && (count_nxt == '0);
        set_vec[FLG_PKT_DONE]  = done && irq_req;
        set_vec[FLG_WAIT_BUF]  = done && chain && (count_nxt == '0);
        clr_vec = stat_wr ? clr_mask : '0;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    flags[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q      <= '0;
            irq_en     <= 1'b0;
            test_force <= 1'b0;
        end else begin
            if (done) begin
                tag_q <= tag;
            end
            if (ctrl_wr) begin
                irq_en     <= ctrl_wdata[0];
                test_force <= ctrl_wdata[1];
            end
        end
    end

    always_comb begin
        irq = irq_en && (flags[FLG_CHAIN_ERR] || flags[FLG_CNT_ZERO] ||
                         flags[FLG_PKT_DONE] ||
                         (test_force && flags[FLG_WAIT_BUF]));
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_req) |=> flags[FLG_PKT_DONE]);                  // R9
    AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_mask[FLG_CHAIN_ERR] && !(done && !chain && (count_nxt != '0)))
        |=> !flags[FLG_CHAIN_ERR]);                                  // R9
    AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_en);                                      // R10
    AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (tag_q == $past(tag)));                             // R11

endmodule

// File: rtl/pkt_status_unit.sv
module pkt_status_unit
    import psu_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pkt_done,
    input  logic              pkt_chain,
    input  logic              pkt_irq_req,
    input  logic [TAG_W-1:0]  pkt_tag,
    output logic              irq
);
    localparam int CNT_LSB = 16;
    localparam int ST_LSB  = 8;
    localparam int TAG_LSB = DATA_W - TAG_W;

    logic                 cnt_wr;
    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     count_nxt;
    cnt_state_e           state;
    logic [NUM_FLAGS-1:0] flags;
    logic [TAG_W-1:0]     tag_q;
    logic                 irq_en;
    logic                 test_force;
    logic                 unused_wdata_bits;

    assign cnt_wr            = reg_wr && (reg_addr == ADDR_CNT);
    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:CNT_W];

    psu_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (cnt_wr),
        .inc_val   (reg_wdata[CNT_W-1:0]),
        .dec       (pkt_done),
        .chain     (pkt_chain),
        .count     (count),
        .count_nxt (count_nxt),
        .state     (state)
    );

    psu_status #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (reg_wr && (reg_addr == ADDR_CTRL)),
        .stat_wr    (reg_wr && (reg_addr == ADDR_STAT)),
        .ctrl_wdata (reg_wdata[1:0]),
        .clr_mask   (reg_wdata[NUM_FLAGS-1:0]),
        .done       (pkt_done),
        .chain      (pkt_chain),
        .irq_req    (pkt_irq_req),
        .tag        (pkt_tag),
        .count      (count),
        .count_nxt  (count_nxt),
        .flags      (flags),
        .tag_q      (tag_q),
        .irq_en     (irq_en),
        .test_force (test_force),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[0] = irq_en;
                reg_rdata[1] = test_force;
            end
            ADDR_CNT: begin
                reg_rdata[CNT_LSB +: CNT_W] = count;
                reg_rdata[ST_LSB +: 2]      = state;
            end
            ADDR_STAT: begin
                reg_rdata[TAG_LSB +: TAG_W]  = tag_q;
                reg_rdata[NUM_FLAGS-1:0]     = flags;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_done && !cnt_wr) |=> $stable(count));                  // R2
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((count != '0) && (count_nxt == '0)) |=> flags[FLG_CNT_ZERO]); // R6

endmodule

// File: tb/pkt_status_unit_bench.sv
module pkt_status_unit_bench;

    typedef struct {
        int          sel;    // 0..3 register address, 4 = irq pin
        logic [31:0] exp;
        string       req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pkt_done = 1'b0;
    logic        pkt_chain = 1'b0;
    logic        pkt_irq_req = 1'b0;
    logic [7:0]  pkt_tag = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    exp_item_t sb_q[$];
    event      sample_ev;
    bit        done_flag = 1'b0;

    always #5 clk = ~clk;

    pkt_status_unit u_pkt_status_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pkt_done    (pkt_done),
        .pkt_chain   (pkt_chain),
        .pkt_irq_req (pkt_irq_req),
        .pkt_tag     (pkt_tag),
        .irq         (irq)
    );

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = (it.sel == 4) ? {31'd0, irq} : reg_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    // Driver: one clock cycle of stimulus, inputs changed at negedge
    task automatic step(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                        input logic dn, input logic ch, input logic rq, input logic [7:0] tg);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        pkt_done = dn; pkt_chain = ch; pkt_irq_req = rq; pkt_tag = tg;
        @(negedge clk);
        reg_wr = 1'b0; pkt_done = 1'b0; pkt_chain = 1'b0; pkt_irq_req = 1'b0;
    endtask

    task automatic expect_val(input int sel, input logic [31:0] exp, input string req);
        exp_item_t it;
        if (sel < 4) reg_addr = sel[1:0];
        it.sel = sel; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        #1;
        -> sample_ev;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_val(0, 32'h0, "R1");
        expect_val(1, 32'h0, "R1");
        expect_val(2, 32'h0, "R1");
        expect_val(4, 32'h0, "R1");
        expect_val(3, 32'h0, "R2");

        // R2 add 5, upper bits ignored; R12 ACTIVE
        step(1, 2'd1, 32'h00FF0005, 0, 0, 0, 8'h00);
        expect_val(1, 32'h00050100, "R2");
        // R5 R11 completion with irq request, irq disabled
        step(0, 2'd0, 0, 1, 1, 1, 8'hA5);
        expect_val(1, 32'h00040100, "R3");
        expect_val(2, 32'hA5000004, "R5");
        expect_val(4, 32'h0, "R10");
        step(1, 2'd0, 32'h1, 0, 0, 0, 8'h00);
        expect_val(4, 32'h1, "R10");
        // R9 write 0 no effect, then write 1 clears
        step(1, 2'd2, 32'h0, 0, 0, 0, 8'h00);
        expect_val(2, 32'hA5000004, "R9");
        step(1, 2'd2, 32'h4, 0, 0, 0, 8'h00);
        expect_val(2, 32'hA5000000, "R9");
        expect_val(4, 32'h0, "R10");
        // R8 chain error
        step(0, 2'd0, 0, 1, 0, 0, 8'h3C);
        expect_val(2, 32'h3C000001, "R8");
        expect_val(4, 32'h1, "R10");
        step(1, 2'd2, 32'h1, 0, 0, 0, 8'h00);
        // R3 simultaneous increment and completion: 3+2-1
        step(1, 2'd1, 32'h2, 1, 1, 0, 8'h11);
        expect_val(1, 32'h00040100, "R3");
        expect_val(2, 32'h11000000, "R11");
        // drain with chain=1 to zero
        for (int i = 0; i < 3; i++) step(0, 2'd0, 0, 1, 1, 0, 8'h22);
        expect_val(1, 32'h00010100, "R3");
        step(0, 2'd0, 0, 1, 1, 0, 8'h33);
        expect_val(1, 32'h00000200, "R12");
        expect_val(2, 32'h3300000A, "R7");
        expect_val(4, 32'h1, "R6");
        step(1, 2'd2, 32'h2, 0, 0, 0, 8'h00);
        expect_val(2, 32'h33000008, "R9");
        expect_val(4, 32'h0, "R10");
        step(1, 2'd0, 32'h3, 0, 0, 0, 8'h00);
        expect_val(0, 32'h3, "R2");
        expect_val(4, 32'h1, "R10");
        step(1, 2'd2, 32'hF, 0, 0, 0, 8'h00);
        expect_val(2, 32'h33000000, "R9");
        expect_val(4, 32'h0, "R10");
        // STARVED -> ACTIVE -> EMPTY with unchained completion
        step(1, 2'd1, 32'h1, 0, 0, 0, 8'h00);
        expect_val(1, 32'h00010100, "R12");
        step(0, 2'd0, 0, 1, 0, 0, 8'h44);
        expect_val(1, 32'h00000000, "R12");
        expect_val(2, 32'h44000002, "R6");
        step(1, 2'd2, 32'hF, 0, 0, 0, 8'h00);
        // completion at zero: count stays 0, count-zero not set
        step(0, 2'd0, 0, 1, 0, 0, 8'h55);
        expect_val(1, 32'h00000000, "R4");
        expect_val(2, 32'h55000000, "R6");
        // saturation at the top
        step(1, 2'd1, 32'hFF, 0, 0, 0, 8'h00);
        step(1, 2'd1, 32'h10, 0, 0, 0, 8'h00);
        expect_val(1, 32'h00FF0100, "R4");
        // set wins over same-cycle clear
        step(1, 2'd2, 32'h4, 1, 1, 1, 8'h66);
        expect_val(1, 32'h00FE0100, "R3");
        expect_val(2, 32'h66000004, "R9");
        expect_val(4, 32'h1, "R10");
        done_flag = 1'b1;
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!done_flag && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
        end
        #20;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule